// File: doc/BRIEF.md
# Selectable-Rate Light Ring Generator

The block drives a ring of eight lamp positions with one of four repeating light patterns. A 2-bit pattern select picks the pattern and a 2-bit rate select picks one of four step intervals. At a 100 MHz clock the intervals are 1.5 s, 1.0 s, 0.5 s and 0.25 s. A hold input freezes the display wherever it stands. Four free-running tick counters produce the candidate step strobes, and a multiplexer picks one of them. A sequencing machine walks the chosen pattern and writes each step's value into an 8-bit pattern register.

The lamp hardware can light only one digit at a time. The 8-bit register is therefore split into two nibbles and shown on two digits in turn. A toggle driven by a slow scan tick alternates between them. The toggle feeds a 1-to-2 decoder that produces the active digit enable. All divisors are parameters, so a simulation can run with short intervals.

Top module: `light_ring_gen`

## Requirements
- R1: A step happens exactly on the cycles where the tick counter chosen by rate_sel wraps. The counters divide by DIV_R0, DIV_R1, DIV_R2 and DIV_R3 for rate_sel 0, 1, 2 and 3. Every counter runs from reset, whatever rate_sel is. The defaults (1.5e8, 1e8, 5e7, 2.5e7) give 1.5 s, 1.0 s, 0.5 s and 0.25 s at 100 MHz. pat_q changes on no other cycle.
- R2: After reset the sequencer is idle. The first step from idle samples pat_sel and loads the first value of that pattern into pat_q.
- R3: Pattern 0 steps through eight values, hex 07, 0E, 1C, 38, 70, E0, C1, 83.
- R4: Pattern 1 steps through four values, hex 05, 14, 50, 41.
- R5: Pattern 2 steps through four values, hex 11, 22, 44, 88.
- R6: Pattern 3 steps through six values, hex 33, E7, CC, F9, 87, 78.
- R7: The step after a pattern's last value returns the sequencer to idle and leaves pat_q unchanged. The next step samples pat_sel again. A change of pat_sel in the middle of a pattern has no effect until that point.
- R8: While hold is 1 no step is taken. pat_q and the sequencer position stay frozen, but the tick counters keep running.
- R9: The digit toggle flips each time a counter dividing by DIV_SCAN wraps. digit_en is 01 with seg_nib = pat_q[3:0] when digit 0 is active. It is 10 with seg_nib = pat_q[7:4] when digit 1 is active.
- R10: An active-low asynchronous reset sets pat_q to 0, digit_en to 01 and the sequencer to idle, and it clears every tick counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pat_sel | input | 2 | Pattern choice, sampled when the sequencer leaves idle |
| rate_sel | input | 2 | Step interval choice |
| hold | input | 1 | Freezes stepping while 1 |
| pat_q | output | 8 | Registered pattern value |
| digit_en | output | 2 | One-hot enable for the active digit |
| seg_nib | output | 4 | Nibble of pat_q for the active digit |

## Verification
Each pattern is run on its own at a different rate. This separates a wrong table entry from a wrong step length or a wrong return to idle. A sweep of rate_sel during one run shows whether the strobe multiplexer picks the right counter, and the mid-run switches expose counters that restart when the selection changes. A hold window and a pat_sel that toggles every few cycles check that the pattern is latched only at idle. A reset in the middle of a run checks the asynchronous clear. A behavioural model compares pat_q, digit_en and seg_nib every clock.

// File: rtl/light_ring_gen.sv
module light_ring_gen #(
  parameter int unsigned DIV_R0   = 150_000_000,
  parameter int unsigned DIV_R1   = 100_000_000,
  parameter int unsigned DIV_R2   = 50_000_000,
  parameter int unsigned DIV_R3   = 25_000_000,
  parameter int unsigned DIV_SCAN = 100_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pat_sel,
  input  logic [1:0] rate_sel,
  input  logic       hold,
  output logic [7:0] pat_q,
  output logic [1:0] digit_en,
  output logic [3:0] seg_nib
);

  localparam int unsigned DIVS [4] = '{DIV_R0, DIV_R1, DIV_R2, DIV_R3};

  function automatic int unsigned max_div();
    int unsigned m = 2;
    for (int i = 0; i < 4; i++) if (DIVS[i] > m) m = DIVS[i];
    return m;
  endfunction

  localparam int unsigned CW = $clog2(max_div());
  localparam int unsigned SW = (DIV_SCAN > 2) ? $clog2(DIV_SCAN) : 1;

  function automatic logic [2:0] last_idx(input logic [1:0] p);
    case (p)
      2'd0:    return 3'd7;
      2'd1:    return 3'd3;
      2'd2:    return 3'd3;
      default: return 3'd5;
    endcase
  endfunction

  function automatic logic [7:0] pat_val(input logic [1:0] p, input logic [2:0] s);
    logic [7:0] v;
    v = 8'h00;
    case (p)
      2'd0: v = ({8'h07, 8'h07} >> (8 - s)) & 8'hFF;
      2'd1: v = 8'h05 << (2 * s[1:0]) | ((s[1:0] == 2'd3) ? 8'h01 : 8'h00);
      2'd2: v = {2{4'b0001 << s[1:0]}};
      default:
        case (s)
          3'd0:    v = 8'h33;
          3'd1:    v = 8'hE7;
          3'd2:    v = 8'hCC;
          3'd3:    v = 8'hF9;
          3'd4:    v = 8'h87;
          default: v = 8'h78;
        endcase
    endcase
    return v;
  endfunction

  logic [3:0] rate_tick;

  for (genvar g = 0; g < 4; g++) begin : g_rate
    localparam logic [CW-1:0] LAST = CW'(DIVS[g] - 1);
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)            cnt <= '0;
      else if (rate_tick[g]) cnt <= '0;
      else                   cnt <= cnt + CW'(1);
    assign rate_tick[g] = (cnt == LAST);
  end

  logic [SW-1:0] scan_cnt;
  logic          scan_tick;
  logic          digit_sel;
  localparam logic [SW-1:0] SCAN_LAST = SW'(DIV_SCAN - 1);

  assign scan_tick = (scan_cnt == SCAN_LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scan_cnt  <= '0;
      digit_sel <= 1'b0;
    end else begin
      scan_cnt <= scan_tick ? '0 : scan_cnt + SW'(1);
      if (scan_tick) digit_sel <= ~digit_sel;
    end

  assign digit_en = digit_sel ? 2'b10 : 2'b01;
  assign seg_nib  = digit_sel ? pat_q[7:4] : pat_q[3:0];

  logic       step_en;
  logic       busy;
  logic [1:0] cur_pat;
  logic [2:0] cur_step;

  assign step_en = rate_tick[rate_sel] & ~hold;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy     <= 1'b0;
      cur_pat  <= 2'd0;
      cur_step <= 3'd0;
      pat_q    <= 8'h00;
    end else if (step_en) begin
      if (!busy) begin
        busy     <= 1'b1;
        cur_pat  <= pat_sel;
        cur_step <= 3'd0;
        pat_q    <= pat_val(pat_sel, 3'd0);
      end else if (cur_step == last_idx(cur_pat)) begin
        busy <= 1'b0;
      end else begin
        cur_step <= cur_step + 3'd1;
        pat_q    <= pat_val(cur_pat, cur_step + 3'd1);
      end
    end

  // R8
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(pat_q));

  // R1
  step_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(pat_q));

  // R9
  scan_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_tick |=> (digit_en != $past(digit_en)));

  // R9
  scan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_tick |=> $stable(digit_en));

  // R7
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cur_step <= last_idx(cur_pat)));

  // R2
  never_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_q != 8'h00) |=> (pat_q != 8'h00));

endmodule

// File: tb/light_ring_gen_tb_top.sv
module light_ring_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int D [4] = '{12, 8, 5, 3};
  localparam int DS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pat_sel = 2'd0;
  logic [1:0] rate_sel = 2'd3;
  logic hold = 1'b0;
  logic [7:0] pat_q;
  logic [1:0] digit_en;
  logic [3:0] seg_nib;

  always #(CLK_PERIOD / 2) clk = ~clk;

  light_ring_gen #(
    .DIV_R0(D[0]), .DIV_R1(D[1]), .DIV_R2(D[2]), .DIV_R3(D[3]), .DIV_SCAN(DS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel), .rate_sel(rate_sel),
    .hold(hold), .pat_q(pat_q), .digit_en(digit_en), .seg_nib(seg_nib)
  );

  int checks = 0;
  int errors = 0;
  string cur_req = "R10";
  bit done = 1'b0;

  function automatic logic [7:0] ref_val(int p, int s);
    logic [7:0] t0 [8] = '{8'h07, 8'h0E, 8'h1C, 8'h38, 8'h70, 8'hE0, 8'hC1, 8'h83};
    logic [7:0] t1 [4] = '{8'h05, 8'h14, 8'h50, 8'h41};
    logic [7:0] t2 [4] = '{8'h11, 8'h22, 8'h44, 8'h88};
    logic [7:0] t3 [6] = '{8'h33, 8'hE7, 8'hCC, 8'hF9, 8'h87, 8'h78};
    case (p)
      0: return t0[s];
      1: return t1[s];
      2: return t2[s];
      default: return t3[s];
    endcase
  endfunction

  function automatic int ref_len(int p);
    case (p)
      0: return 8;
      1: return 4;
      2: return 4;
      default: return 6;
    endcase
  endfunction

  int cnt [4];
  int scnt;
  bit m_busy;
  int m_pat, m_step;
  logic [7:0] m_reg;
  bit m_dsel;
  bit st, sc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) cnt[i] = 0;
      scnt = 0; m_busy = 0; m_pat = 0; m_step = 0; m_reg = 8'h00; m_dsel = 0;
    end else begin
      st = (cnt[rate_sel] == D[rate_sel] - 1) && !hold;
      sc = (scnt == DS - 1);
      for (int i = 0; i < 4; i++) cnt[i] = (cnt[i] == D[i] - 1) ? 0 : cnt[i] + 1;
      scnt = sc ? 0 : scnt + 1;
      if (sc) m_dsel = !m_dsel;
      if (st) begin
        if (!m_busy) begin
          m_busy = 1; m_pat = pat_sel; m_step = 0; m_reg = ref_val(m_pat, 0);
        end else if (m_step == ref_len(m_pat) - 1) begin
          m_busy = 0;
        end else begin
          m_step++; m_reg = ref_val(m_pat, m_step);
        end
      end
    end
  end

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, "pat_q", pat_q, m_reg);
      chk("R9", "digit_en", {6'b0, digit_en}, m_dsel ? 8'h02 : 8'h01);
      chk("R9", "seg_nib", {4'b0, seg_nib}, {4'b0, m_dsel ? m_reg[7:4] : m_reg[3:0]});
    end
  end

  task automatic run(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  initial begin
    #(CLK_PERIOD * 2 + 1);
    chk("R10", "pat_q in reset", pat_q, 8'h00);
    chk("R10", "digit_en in reset", {6'b0, digit_en}, 8'h01);
    @(posedge clk); #2 rst_n = 1'b1;
    cur_req = "R2"; run(4);
    cur_req = "R3"; run(60);
    pat_sel = 2'd1; rate_sel = 2'd2; cur_req = "R4"; run(80);
    pat_sel = 2'd2; rate_sel = 2'd1; cur_req = "R5"; run(100);
    pat_sel = 2'd3; rate_sel = 2'd0; cur_req = "R6"; run(200);
    cur_req = "R8"; hold = 1'b1; run(60); hold = 1'b0;
    cur_req = "R1";
    for (int r = 0; r < 4; r++) begin rate_sel = 2'(r); run(50); end
    cur_req = "R7"; rate_sel = 2'd3;
    for (int k = 0; k < 50; k++) begin pat_sel = 2'(k); run(3); end
    cur_req = "R10";
    @(posedge clk); #2 rst_n = 1'b0;
    #1;
    chk("R10", "pat_q after async reset", pat_q, 8'h00);
    chk("R10", "digit_en after async reset", {6'b0, digit_en}, 8'h01);
    run(2); rst_n = 1'b1; pat_sel = 2'd0; run(40);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule